// File: doc/BRIEF.md
# Clock Failure Detection Monitor

This block decides whether a monitored clock is still running. It uses a free-running reference oscillator as its time base. The reference is divided by a parameter (64 by default) to form a slow sample period. A one-bit "seen" flag is cleared when each sample period opens. Any falling transition of the monitored clock sets the flag. At the middle of the period, the flag is checked. If no falling transition arrived in the first half, the block raises a one-cycle failure pulse in the reference domain.

The monitored clock is treated as data. A two-flop synchronizer brings it into the reference domain, and a third flop detects its falling transitions there, so all state lives on the reference clock. The monitored clock is expected to run far faster than the sample rate. At a 31.25 kHz reference, the sample rate is about 488 Hz and the period is about 2.048 ms. Switching to a spare clock, and any interrupt generation, belong to the consumer of `fail_o`.

Top module: `clk_fail_mon`

## Requirements
- R1: While `rst_ni` is low, `fail_o` is 0. After release, with the monitored clock stopped, the first failure pulse is seen after the 97th reference rising edge (DIV + DIV/2 + 1), never earlier.
- R2: With the monitored clock stopped, failure pulses repeat exactly once per sample period of DIV (64) reference cycles.
- R3: A falling transition of `mon_clk_i` counts for the current sample period if it is registered in the reference domain within the first half of that period. A transition on `mon_clk_i` takes two synchronizer cycles plus one detection cycle to reach the flag. A monitored clock that toggles every 3 reference cycles never causes a failure pulse.
- R4: If no falling transition reaches the flag in the first half of a sample period, a failure pulse follows the mid-period check after one register stage. Falling transitions that occur only in the second half do not prevent the pulse.
- R5: `fail_o` is high for exactly one reference cycle per detection, and pulses at most once per sample period.
- R6: While `enable_i` is low, `fail_o` stays 0, and the sample divider and the seen flag are held cleared.
- R7: After `enable_i` goes from low to high, the first check is suppressed until a full sample period has elapsed. With a stopped monitored clock, the first pulse comes after the 97th enabled reference edge.
- R8: Only falling transitions count. A monitored input that rises once and stays high is reported as failed every sample period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Free-running reference clock; all state is clocked by it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | 1 | Monitored clock, sampled as asynchronous data |
| enable_i | input | 1 | Monitoring enable, synchronous to `ref_clk_i` |
| fail_o | output | 1 | One-cycle pulse when a sample period shows no monitored falling transition |

## Verification
The hardest situation to reach is a monitored clock that is alive but only produces falling transitions in the untested second half of the sample period. A free-running stimulus clock never lands there reliably. The bench therefore counts reference cycles from the moment it raises the enable, so it knows the divider phase. From that count it shapes a single high pulse on the monitored input whose falling transition lands either early or late in the period. A cycle-accurate behavioural model in the bench, which includes the three-cycle synchronization delay, tells which of the two cases must fail.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    // Synchronizer and history flops for the monitored clock
    typedef struct packed {
        logic meta;
        logic sync;
        logic hist;
    } sync_state_t;

    // Per-period detection state
    typedef struct packed {
        logic seen;
        logic fail;
    } win_state_t;

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync
    import clkmon_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic fall_o
);

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.sync = st_q.meta;
        st_d.hist = st_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Old level high, new level low: a falling transition
    assign fall_o = st_q.hist & ~st_q.sync;

endmodule

// File: rtl/clkmon_sample_div.sv
module clkmon_sample_div #(
    parameter int unsigned DIV = 64
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   en_i,
    output logic [$clog2(DIV)-1:0] phase_o,
    output logic                   open_o,
    output logic                   test_o,
    output logic                   armed_o
);

    localparam int unsigned PW   = $clog2(DIV);
    localparam int unsigned HALF = DIV / 2;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] MID  = PW'(HALF);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          armed;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else begin
            st_d.cnt   = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
            st_d.armed = st_q.armed | (st_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign phase_o = st_q.cnt;
    assign open_o  = (st_q.cnt == '0);
    assign test_o  = (st_q.cnt == MID);
    assign armed_o = st_q.armed;

endmodule

// File: rtl/clkmon_window.sv
module clkmon_window
    import clkmon_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic open_i,
    input  logic test_i,
    input  logic armed_i,
    input  logic fall_i,
    output logic fail_o
);

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else begin
            // Opening a period discards earlier activity
            st_d.seen = open_i ? fall_i : (st_q.seen | fall_i);
            st_d.fail = test_i & armed_i & ~st_q.seen;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fail_o = st_q.fail;

endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon #(
    parameter int unsigned DIV = 64
) (
    input  logic ref_clk_i,
    input  logic rst_ni,
    input  logic mon_clk_i,
    input  logic enable_i,
    output logic fail_o
);

    localparam int unsigned PW = $clog2(DIV);

    logic          fall_w;
    logic          open_w;
    logic          test_w;
    logic          armed_w;
    logic [PW-1:0] phase_w;

    clkmon_edge_sync u_sync (
        .clk_i  (ref_clk_i),
        .rst_ni (rst_ni),
        .async_i(mon_clk_i),
        .fall_o (fall_w)
    );

    clkmon_sample_div #(.DIV(DIV)) u_div (
        .clk_i  (ref_clk_i),
        .rst_ni (rst_ni),
        .en_i   (enable_i),
        .phase_o(phase_w),
        .open_o (open_w),
        .test_o (test_w),
        .armed_o(armed_w)
    );

    clkmon_window u_win (
        .clk_i  (ref_clk_i),
        .rst_ni (rst_ni),
        .en_i   (enable_i),
        .open_i (open_w),
        .test_i (test_w),
        .armed_i(armed_w),
        .fall_i (fall_w),
        .fail_o (fail_o)
    );

endmodule

// File: rtl/clk_fail_mon_chk.sv
module clk_fail_mon_chk #(
    parameter int unsigned DIV = 64
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   en_i,
    input logic                   fail_i,
    input logic [$clog2(DIV)-1:0] phase_i
);

    localparam int unsigned PW    = $clog2(DIV);
    localparam int unsigned FIRST = DIV + DIV / 2 + 1;
    localparam int unsigned CW    = $clog2(FIRST + 1);

    logic [CW-1:0] en_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    en_cnt_q <= '0;
        else if (!en_i)                 en_cnt_q <= '0;
        else if (en_cnt_q < CW'(FIRST)) en_cnt_q <= en_cnt_q + 1'b1;
    end

    // R2
    mid_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |-> $past(phase_i) == PW'(DIV / 2));

    // R5
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |=> !fail_i);

    // R6
    quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !fail_i);

    // R7
    first_check_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |-> en_cnt_q >= CW'(FIRST));

endmodule

bind clk_fail_mon clk_fail_mon_chk #(.DIV(DIV)) u_chk (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .en_i   (enable_i),
    .fail_i (fail_o),
    .phase_i(phase_w)
);

// File: tb/clk_fail_mon_bench.sv
`timescale 1ns/1ps
module clk_fail_mon_bench;

    localparam int DIV  = 64;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon = 1'b0;
    logic en = 1'b1;
    logic fail;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // stimulus control
    int mode = 0;        // 0 level, 1 free toggle, 2 phase-placed pulse
    logic lvl = 1'b0;
    int tog = 0;
    int n = 0;
    int lo = 0, hi = 0;
    int pulses = 0;
    logic prev_fail = 1'b0;

    // reference model state
    int  m_phase = 0;
    bit  m_armed = 0, m_seen = 0, m_fail = 0;
    bit  hist[$] = '{0, 0, 0};
    bit  m_edge, m_nf;

    always #10 clk = ~clk;

    clk_fail_mon #(.DIV(DIV)) u_clk_fail_mon (
        .ref_clk_i(clk),
        .rst_ni   (rst_n),
        .mon_clk_i(mon),
        .enable_i (en),
        .fail_o   (fail)
    );

    // Behavioural model: monitored samples pass three reference cycles before counting
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_armed = 0; m_seen = 0; m_fail = 0;
            hist = '{0, 0, 0};
        end else begin
            m_edge = hist[0] && !hist[1];
            if (!en) begin
                m_phase = 0; m_armed = 0; m_seen = 0; m_fail = 0;
            end else begin
                m_nf   = (m_phase == HALF) && m_armed && !m_seen;
                m_seen = (m_phase == 0) ? m_edge : (m_seen || m_edge);
                if (m_phase == DIV - 1) begin
                    m_armed = 1;
                    m_phase = 0;
                end else begin
                    m_phase = m_phase + 1;
                end
                m_fail = m_nf;
            end
            void'(hist.pop_front());
            hist.push_back(mon);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            check(m_fail ? "R4" : "R3", fail, m_fail);
            if (fail && prev_fail) check("R5", 1, 0);
        end
        if (fail) pulses++;
        prev_fail = fail;
        n++;
        case (mode)
            0: mon = lvl;
            1: begin
                tog++;
                if (tog >= 3) begin mon = ~mon; tog = 0; end
            end
            default: mon = ((n % DIV) >= lo) && ((n % DIV) < hi);
        endcase
    endtask

    task automatic run(input int cyc);
        for (int i = 0; i < cyc; i++) tick();
    endtask

    task automatic first_fail(input string req);
        int first = -1;
        for (int j = 1; j <= 300; j++) begin
            tick();
            if (fail && first < 0) first = j;
        end
        check(req, first, DIV + HALF + 1);
    endtask

    initial begin
        run(5);
        check("R1", fail, 0);
        // release reset with a stopped monitored clock
        rst_n = 1'b1; n = 0;
        first_fail("R1");

        // stopped low: one pulse per period
        pulses = 0; run(5 * DIV);
        check("R2", pulses, 5);

        // rises once then stays high: still failed
        lvl = 1'b1; run(8);
        pulses = 0; run(5 * DIV);
        check("R8", pulses, 5);

        // healthy fast clock
        mode = 1; run(2 * DIV);
        pulses = 0; run(10 * DIV);
        check("R3", pulses, 0);

        // disabled with a stopped clock
        mode = 0; lvl = 1'b0; en = 1'b0;
        pulses = 0; run(5 * DIV);
        check("R6", pulses, 0);

        // re-enable: first check waits a full period
        en = 1'b1; n = 0;
        first_fail("R7");

        // falling transition early in each period: no failure
        en = 1'b0; run(2);
        mode = 2; lo = 4; hi = 10; en = 1'b1; n = 0;
        pulses = 0; run(10 * DIV);
        check("R3", pulses, 0);

        // falling transition only in the second half: failure every period
        en = 1'b0; run(2);
        lo = 40; hi = 48; en = 1'b1; n = 0;
        pulses = 0; run(10 * DIV);
        check("R4", pulses, 9);

        // reset in the middle of activity
        rst_n = 1'b0; run(3);
        check("R1", fail, 0);
        mode = 0; lvl = 1'b0; rst_n = 1'b1; n = 0;
        first_fail("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule